// File: doc/BRIEF.md
# Sequential Booth Multiplier with Guard Bit

This block forms the signed product of two two's-complement operands, one bit of the multiplier per clock, using radix-2 Booth recoding. A caller raises `start` for one cycle while the block is idle, with the multiplicand and multiplier on their inputs. The block loads a working register and then, on each of the next YW clock edges, looks at the two lowest bits of that register. It adds the shifted multiplicand, adds its negation, or does neither. Then it shifts the whole register one place right and keeps the sign.

The working register is one bit wider than the textbook layout. The multiplicand and its negation are both sign-extended by that bit. As a result, the most negative multiplicand, whose negation does not fit in XW bits, still produces a correct product. When the last step is done, `done` pulses for one cycle. `product` then shows the result and holds it until the next completed operation.

Top module: `booth_seq_mul`

## Requirements
- R1: After an operation completes, `product` equals the signed product of the multiplicand and multiplier that were sampled when `start` was accepted. This holds for every operand pair, including one or both operands at the most negative value (for example -8 x 2 = -16 and -8 x -8 = 64 with 4-bit operands).
- R2: `done` is high for exactly one cycle. It rises at the YW-th rising edge after the edge that accepted `start`.
- R3: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `busy` and `done` are never high together.
- R4: While `busy` is high, `start` and any change on the operand inputs have no effect on the result or on the timing of the operation in progress.
- R5: While `busy` is low, `product` does not change, whatever `start` and the operands do.
- R6: After reset, `busy`, `done` and `product` are all zero.
- R7: Without an accepted `start`, `done` never rises.
- R8: A `start` raised in the cycle where `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| mcand | input | XW | Signed multiplicand |
| mplier | input | YW | Signed multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | XW+YW | Signed product, held until the next completion |

## Verification
The bench builds two copies of the block. One uses 4-bit operands, which makes the full set of 256 operand pairs cheap to sweep. That sweep includes the most negative multiplicand against every multiplier, and both operands at -8. The other copy uses 8-bit operands and runs a table of corner pairs such as -128 x -128 and -128 x 127, followed by random pairs. Its 8-step latency also leaves room to disturb the inputs while the block is busy and to start a new operation in the cycle `done` is high.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    BOP_HOLD = 2'd0,
    BOP_ADD  = 2'd1,
    BOP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic [1:0] pair,
  output booth_op_e  op
);
  // pair = {current multiplier bit, previously examined bit}
  always_comb begin
    unique case (pair)
      2'b01:   op = BOP_ADD;
      2'b10:   op = BOP_SUB;
      default: op = BOP_HOLD;
    endcase
  end
endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int W = 11
) (
  input  logic [W-1:0] p_cur,
  input  logic [W-1:0] add_word,
  input  logic [W-1:0] sub_word,
  input  booth_op_e    op,
  output logic [W-1:0] p_next
);
  logic [W-1:0] sum;

  always_comb begin
    unique case (op)
      BOP_ADD: sum = p_cur + add_word;
      BOP_SUB: sum = p_cur + sub_word;
      default: sum = p_cur;
    endcase
    p_next = {sum[W-1], sum[W-1:1]};
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic accept,
  output logic last
);
  localparam int CW = $clog2(STEPS + 1);

  logic [CW-1:0] left_q;
  logic          busy_q;

  assign busy   = busy_q;
  assign accept = start && !busy_q;
  assign last   = busy_q && (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      left_q <= CW'(STEPS);
    end else if (busy_q) begin
      left_q <= left_q - CW'(1);
      if (last) busy_q <= 1'b0;
    end
  end

  assert_count_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != '0));
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_pkg::*;
#(
  parameter int XW = 8,
  parameter int YW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [XW-1:0]    mcand,
  input  logic signed [YW-1:0]    mplier,
  output logic                    busy,
  output logic                    done,
  output logic signed [XW+YW-1:0] product
);
  localparam int W  = XW + YW + 2;
  localparam int PW = XW + YW;

  logic          accept, last;
  logic [W-1:0]  p_q, p_nxt, add_word, sub_word;
  logic [XW:0]   m_q, m_neg;
  logic [PW-1:0] prod_q;
  logic          done_q;
  booth_op_e     op;

  booth_ctrl #(.STEPS(YW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .accept(accept), .last(last)
  );

  booth_recode u_recode (.pair(p_q[1:0]), .op(op));

  always_comb begin
    m_neg    = (~m_q) + (XW+1)'(1);
    add_word = {m_q,   {(YW+1){1'b0}}};
    sub_word = {m_neg, {(YW+1){1'b0}}};
  end

  booth_step #(.W(W)) u_step (
    .p_cur(p_q), .add_word(add_word), .sub_word(sub_word),
    .op(op), .p_next(p_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q    <= '0;
      m_q    <= '0;
      prod_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        p_q <= {{(XW+1){1'b0}}, mplier, 1'b0};
        m_q <= {mcand[XW-1], mcand};
      end else if (busy) begin
        p_q <= p_nxt;
        if (last) begin
          prod_q <= p_nxt[W-2:1];
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done    = done_q;
  assign product = prod_q;

  // Checking logic: reference operands and latency counter
  logic signed [XW-1:0] ref_a;
  logic signed [YW-1:0] ref_b;
  logic signed [PW-1:0] ref_prod;
  logic [15:0]          lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_a <= '0;
      ref_b <= '0;
      lat_q <= '0;
    end else if (accept) begin
      ref_a <= mcand;
      ref_b <= mplier;
      lat_q <= '0;
    end else if (busy) begin
      lat_q <= lat_q + 16'd1;
    end
  end

  always_comb ref_prod = ref_a * ref_b;

  assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == ref_prod));
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == 16'(YW)));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(product));
endmodule

// File: tb/test_booth_seq_mul.sv
`timescale 1ns/1ps
module test_booth_seq_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // 8x8 instance
  logic              st8 = 1'b0;
  logic signed [7:0] a8 = '0, b8 = '0;
  logic              bz8, dn8;
  logic signed [15:0] p8;
  // 4x4 instance
  logic              st4 = 1'b0;
  logic signed [3:0] a4 = '0, b4 = '0;
  logic              bz4, dn4;
  logic signed [7:0] p4;

  booth_seq_mul #(.XW(8), .YW(8)) i_booth_seq_mul (
    .clk(clk), .rst_n(rst_n), .start(st8), .mcand(a8), .mplier(b8),
    .busy(bz8), .done(dn8), .product(p8));

  booth_seq_mul #(.XW(4), .YW(4)) i_booth_seq_mul_w4 (
    .clk(clk), .rst_n(rst_n), .start(st4), .mcand(a4), .mplier(b4),
    .busy(bz4), .done(dn4), .product(p4));

  localparam int NV = 10;
  localparam logic signed [7:0] TA [NV] =
    '{8'sd3, -8'sd128, -8'sd128, 8'sd127, 8'sd0, -8'sd1, -8'sd8, 8'sd100, -8'sd128, 8'sd1};
  localparam logic signed [7:0] TB [NV] =
    '{-8'sd4, -8'sd128, 8'sd127, 8'sd127, -8'sd1, -8'sd1, 8'sd2, -8'sd3, 8'sd1, -8'sd128};
  localparam logic signed [15:0] TP [NV] =
    '{-16'sd12, 16'sd16384, -16'sd16256, 16'sd16129, 16'sd0, 16'sd1, -16'sd16, -16'sd300, -16'sd128, -16'sd128};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run8(input logic signed [7:0] a, input logic signed [7:0] b, output int lat);
    a8 = a; b8 = b; st8 = 1'b1;
    @(negedge clk);
    st8 = 1'b0;
    lat = 0;
    while (!dn8 && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run4(input logic signed [3:0] a, input logic signed [3:0] b, output int lat);
    a4 = a; b4 = b; st4 = 1'b1;
    @(negedge clk);
    st4 = 1'b0;
    lat = 0;
    while (!dn4 && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic signed [15:0] keep;
    repeat (3) @(negedge clk);
    // R6: reset state
    chk(bz8 == 0 && dn8 == 0, "R6 busy/done in reset", {bz8, dn8}, 0);
    chk(p8 == 0 && p4 == 0, "R6 product in reset", p8, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bz8 == 0 && dn8 == 0 && p8 == 0, "R6 after reset release", p8, 0);

    // R7: no done without start
    for (int i = 0; i < 10; i++) begin
      a8 = 8'(i * 7); b8 = 8'(i * 13);
      @(negedge clk);
      chk(dn8 == 0 && bz8 == 0, "R7 no done while idle", dn8, 0);
    end

    // R1 R2: table of corner vectors
    for (int i = 0; i < NV; i++) begin
      run8(TA[i], TB[i], lat);
      chk(p8 == TP[i], "R1 table product", p8, TP[i]);
      chk(lat == 8, "R2 table latency", lat, 8);
      @(negedge clk);
      chk(dn8 == 0, "R2 done one cycle", dn8, 0);
    end

    // R1: exhaustive 4x4 including -8 x -8
    for (int x = -8; x < 8; x++) begin
      for (int y = -8; y < 8; y++) begin
        run4(4'(x), 4'(y), lat);
        chk(p4 == 8'(x * y), "R1 exhaustive 4-bit", p4, x * y);
        chk(lat == 4, "R2 latency 4-bit", lat, 4);
      end
    end

    // R1: random 8x8
    for (int i = 0; i < 300; i++) begin
      logic signed [7:0] ra, rb;
      ra = 8'($urandom());
      rb = 8'($urandom());
      run8(ra, rb, lat);
      chk(p8 == 16'(int'(ra) * int'(rb)), "R1 random 8-bit", p8, int'(ra) * int'(rb));
    end

    // R3 R4: disturb inputs while busy
    a8 = 8'sd5; b8 = -8'sd7; st8 = 1'b1;
    @(negedge clk);
    st8 = 1'b0;
    chk(bz8 == 1, "R3 busy after accept", bz8, 1);
    @(negedge clk);
    a8 = 8'sd99; b8 = 8'sd99; st8 = 1'b1;
    lat = 1;
    repeat (3) begin
      @(negedge clk);
      lat++;
      chk(bz8 == 1 && dn8 == 0, "R3 busy during run", bz8, 1);
    end
    st8 = 1'b0;
    while (!dn8 && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 8, "R4 latency unaffected by start while busy", lat, 8);
    chk(p8 == -16'sd35, "R4 result unaffected by input changes", p8, -35);
    chk(bz8 == 0, "R3 busy low with done", bz8, 0);

    // R5: product held while idle
    keep = p8;
    for (int i = 0; i < 4; i++) begin
      a8 = 8'(i + 40); b8 = 8'(i - 60);
      @(negedge clk);
      chk(p8 == keep, "R5 product held while idle", p8, keep);
    end

    // R8: back-to-back starts
    run8(8'sd7, -8'sd9, lat);
    chk(p8 == -16'sd63, "R8 first of pair", p8, -63);
    chk(bz8 == 0 && dn8 == 1, "R8 idle with done", bz8, 0);
    run8(-8'sd128, -8'sd128, lat);
    chk(lat == 8, "R8 start in done cycle accepted", lat, 8);
    chk(p8 == 16'sd16384, "R8 second of pair", p8, 16384);

    // R6: reset mid-operation
    a8 = 8'sd3; b8 = 8'sd3; st8 = 1'b1;
    @(negedge clk);
    st8 = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(bz8 == 0 && dn8 == 0 && p8 == 0, "R6 reset mid-run", p8, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule